// File: doc/BRIEF.md
# Six-Channel Word Steering Sequencer

This block accepts a 10-bit parallel word on every pixel-clock edge and writes it into one of six first-stage holding latches. The target latch is picked in one of two ways. In addressed mode a 3-bit channel code names the latch directly, and the start/select input acts as an enable. In sequenced mode the channel code is all ones. A start pulse then launches an internal counter, which fills all six latches one after another, either upward from channel 0 or downward from channel 5.

The pixel clock has two edges, and both are used. The block runs on a clock at twice the pixel rate. A slot flag marks each fast cycle as standing for either a rising or a falling pixel edge. In sequenced mode an even/odd select input decides which kind of slot captures data. Two copies of the block can therefore share one data bus, one taking the even words and the other the odd words. Each write produces a one-cycle strobe on the written channel and a copy of the captured word. All six latch contents are presented on a flat output bus for the transfer stage that follows.

A standby input clears everything and blocks all loads while it is high.

Top module: `chan_load_seq`

## Requirements
- R1: In addressed mode, the channel code (0 to 5) and the select input are sampled on a rising slot (`tick_rise`=1). On the next falling slot, `data_in` is written into that channel. The channel code presented during the falling slot is ignored.
- R2: When the select input is low on the rising slot, the following falling slot writes no channel.
- R3: Channel code 6 is reserved. A rising slot that samples it, even with select high, causes no write on the following falling slot.
- R4: Channel code 7 (all ones) with the start input high on a rising slot arms the sequencer. The first sequenced write lands on the first capture slot after that rising slot.
- R5: When `dir_down` is low at the arming slot, sequenced writes visit channels 0,1,2,3,4,5 in turn. When it is high, they visit 5,4,3,2,1,0.
- R6: In sequenced mode, `even_sel`=1 makes rising slots the capture slots and `even_sel`=0 makes falling slots the capture slots. Exactly one write happens per capture slot while the sequence runs.
- R7: After its sixth write the sequencer goes idle. It makes no further writes until a new start pulse arrives.
- R8: While `standby` is high, all six latches, the strobes and the captured word are forced to zero and no write happens. A running sequence is abandoned and does not resume when standby drops.
- R9: `load_stb` has at most one bit set and is high for exactly the one cycle after a write. Bit i marks channel i. `cap_word` then equals the written word, and latches that were not written keep their contents.
- R10: After reset, all latches, `load_stb` and `cap_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_rise | input | 1 | 1: this cycle is a rising pixel-edge slot; 0: a falling slot |
| standby | input | 1 | High clears all state and blocks writes |
| data_in | input | 10 | Word to be captured |
| chan_addr | input | 3 | 0-5 direct channel, 6 reserved, 7 sequenced mode |
| start_cs | input | 1 | Start pulse (sequenced) or select (addressed) |
| dir_down | input | 1 | Sequence order: 0 upward, 1 downward |
| even_sel | input | 1 | Sequenced capture slot: 1 rising, 0 falling |
| load_stb | output | 6 | One-cycle write strobe per channel |
| cap_word | output | 10 | Last word written |
| bank_q | output | 60 | Latch contents, channel i at bits [10i+9:10i] |

## Verification
A fault in the sequencer's pointer or remaining-count state shows up at the very next capture slot. Either `load_stb` lights the wrong bit, or a latch receives a word intended for another channel, or a seventh write appears after the run should have ended. A stale address register shows as a write to the decoy channel presented during the falling slot. A faulty standby path leaves nonzero latch contents visible on `bank_q` one cycle after standby rises. The bench sweeps every channel code, both sequence directions and both capture slots, so each of these faults is caught within a few slots of where it arises.

// File: rtl/chs_pkg.sv
package chs_pkg;

  // first channel visited by a sequence run
  function automatic int unsigned seq_first(input bit down, input int unsigned nch);
    return down ? nch - 1 : 0;
  endfunction

  // channel visited after idx
  function automatic int unsigned seq_step(input int unsigned idx, input bit down);
    return down ? idx - 1 : idx + 1;
  endfunction

  // one-hot strobe for a channel index
  function automatic int unsigned onehot_of(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int unsigned CH = 6,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          tick_rise,
  input  logic [AW-1:0] addr,
  input  logic          cs,
  output logic          req_valid,
  output logic [AW-1:0] req_idx
);
  localparam logic [AW-1:0] NCH_A = AW'(CH);

  logic [AW-1:0] addr_q;
  logic          cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cs_q   <= 1'b0;
    end else if (standby) begin
      addr_q <= '0;
      cs_q   <= 1'b0;
    end else if (tick_rise) begin
      addr_q <= addr;
      cs_q   <= cs;
    end
  end

  // a falling slot writes the channel held from the preceding rising slot
  assign req_valid = !tick_rise && cs_q && (addr_q < NCH_A);
  assign req_idx   = addr_q;

  // R2
  cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rise && !cs) |=> !req_valid);

  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rise && addr == NCH_A) |=> !req_valid);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int unsigned CH = 6,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          arm,
  input  logic          cap_tick,
  input  logic          mode_seq,
  input  logic          dir_down,
  output logic          seq_valid,
  output logic [AW-1:0] seq_idx
);
  import chs_pkg::*;

  localparam int unsigned LW = $clog2(CH + 2);

  logic          busy;
  logic          down_q;
  logic [LW-1:0] left;
  logic [AW-1:0] idx;

  assign seq_valid = busy && cap_tick && mode_seq && !arm;
  assign seq_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      down_q <= 1'b0;
      left   <= '0;
      idx    <= '0;
    end else if (standby) begin
      busy   <= 1'b0;
      down_q <= 1'b0;
      left   <= '0;
      idx    <= '0;
    end else if (arm) begin
      busy   <= 1'b1;
      down_q <= dir_down;
      left   <= LW'(CH);
      idx    <= AW'(seq_first(dir_down, CH));
    end else if (seq_valid) begin
      idx  <= AW'(seq_step(idx, down_q));
      left <= left - 1'b1;
      if (left == LW'(1)) busy <= 1'b0;
    end
  end

  // checker-only count of writes since the last arming
  logic [LW-1:0] loads_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       loads_run <= '0;
    else if (standby || arm)          loads_run <= '0;
    else if (seq_valid)               loads_run <= loads_run + 1'b1;
  end

  // R7
  seq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loads_run <= LW'(CH));

  // R5
  seq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |-> (seq_idx < AW'(CH)));

endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int unsigned CH = 6,
  parameter int unsigned DW = 10,
  parameter int unsigned AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [CH*DW-1:0] bank,
  output logic [CH-1:0]    stb,
  output logic [DW-1:0]    word
);
  import chs_pkg::*;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   r <= '0;
      else if (standby)                             r <= '0;
      else if (wr_en && wr_idx == AW'(i))           r <= wr_data;
    end
    assign bank[i*DW +: DW] = r;

    // R9
    stb_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb[i] |-> (bank[i*DW +: DW] == word));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb  <= '0;
      word <= '0;
    end else if (standby) begin
      stb  <= '0;
      word <= '0;
    end else begin
      stb <= wr_en ? CH'(onehot_of(wr_idx)) : '0;
      if (wr_en) word <= wr_data;
    end
  end

  // R9
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

endmodule

// File: rtl/chan_load_seq.sv
module chan_load_seq #(
  parameter int unsigned CH = 6,
  parameter int unsigned DW = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_rise,
  input  logic                       standby,
  input  logic [DW-1:0]              data_in,
  input  logic [$clog2(CH+2)-1:0]    chan_addr,
  input  logic                       start_cs,
  input  logic                       dir_down,
  input  logic                       even_sel,
  output logic [CH-1:0]              load_stb,
  output logic [DW-1:0]              cap_word,
  output logic [CH*DW-1:0]           bank_q
);
  localparam int unsigned AW = $clog2(CH + 2);

  // named internal events
  logic          cap_tick;
  logic          mode_seq;
  logic          arm;
  logic          req_valid;
  logic [AW-1:0] req_idx;
  logic          seq_valid;
  logic [AW-1:0] seq_idx;
  logic          wr_en;
  logic [AW-1:0] wr_idx;

  assign cap_tick = even_sel ? tick_rise : !tick_rise;
  assign mode_seq = (chan_addr == '1);
  assign arm      = tick_rise && start_cs && mode_seq && !standby;

  addr_decode #(.CH(CH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tick_rise(tick_rise),
    .addr(chan_addr), .cs(start_cs), .req_valid(req_valid), .req_idx(req_idx)
  );

  seq_ctrl #(.CH(CH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .standby(standby), .arm(arm),
    .cap_tick(cap_tick), .mode_seq(mode_seq), .dir_down(dir_down),
    .seq_valid(seq_valid), .seq_idx(seq_idx)
  );

  // addressed request wins if both are present in one slot
  assign wr_en  = req_valid || seq_valid;
  assign wr_idx = req_valid ? req_idx : seq_idx;

  latch_bank #(.CH(CH), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(data_in), .bank(bank_q), .stb(load_stb),
    .word(cap_word)
  );

  // R8
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (load_stb == '0 && bank_q == '0 && cap_word == '0));

  // R6
  seq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !req_valid) |-> (tick_rise == even_sel));

endmodule

// File: tb/chan_load_seq_test.sv
`timescale 1ns/1ps
module chan_load_seq_test;
  localparam int CH = 6;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_rise = 1'b0, standby = 1'b0, start_cs = 1'b0;
  logic dir_down = 1'b0, even_sel = 1'b1;
  logic [DW-1:0] data_in = '0;
  logic [2:0] chan_addr = '0;
  logic [CH-1:0] load_stb;
  logic [DW-1:0] cap_word;
  logic [CH*DW-1:0] bank_q;

  int errs = 0, checks = 0, seed = 0;
  logic [DW-1:0] model [CH];

  always #2.5 clk = ~clk;

  chan_load_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .standby(standby),
    .data_in(data_in), .chan_addr(chan_addr), .start_cs(start_cs),
    .dir_down(dir_down), .even_sel(even_sel), .load_stb(load_stb),
    .cap_word(cap_word), .bank_q(bank_q)
  );

  function automatic logic [DW-1:0] dval(input int k);
    return DW'((k * 373 + 41) % 1024);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one fast cycle; exp_ch < 0 means no write expected
  task automatic tick(input bit r, input int exp_ch, input string req);
    logic [CH*DW-1:0] eb;
    logic [DW-1:0] d;
    d = dval(seed);
    seed++;
    tick_rise = r;
    data_in = d;
    @(posedge clk);
    #1;
    if (standby) begin
      for (int i = 0; i < CH; i++) model[i] = '0;
    end else if (exp_ch >= 0) begin
      model[exp_ch] = d;
    end
    for (int i = 0; i < CH; i++) eb[i*DW +: DW] = model[i];
    chk({req, " strobe"}, 64'(load_stb), (exp_ch >= 0 && !standby) ? 64'(1 << exp_ch) : 64'd0);
    chk({req, " bank"}, 64'(bank_q), 64'(eb));
    if (exp_ch >= 0 && !standby) chk({req, " word"}, 64'(cap_word), 64'(d));
  endtask

  task automatic run_seq(input bit down, input bit ev);
    chan_addr = 3'd7; dir_down = down; even_sel = ev; start_cs = 1'b1;
    tick(1'b1, -1, "R4 arm");
    start_cs = 1'b0;
    dir_down = ~down;  // direction is latched at arming
    for (int k = 0; k < CH; k++) begin
      int ch;
      ch = down ? CH - 1 - k : k;
      if (ev) begin
        tick(1'b0, -1, "R6 off slot");
        tick(1'b1, ch, "R5 seq order");
      end else begin
        tick(1'b0, ch, "R5 seq order");
        tick(1'b1, -1, "R6 off slot");
      end
    end
    for (int k = 0; k < 4; k++) tick(k[0] ? 1'b1 : 1'b0, -1, "R7 idle after run");
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < CH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset bank", 64'(bank_q), 64'd0);
    chk("R10 reset strobe", 64'(load_stb), 64'd0);
    chk("R10 reset word", 64'(cap_word), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: addressed writes in two orders, decoy code during the falling slot
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < CH; k++) begin
        int ch;
        ch = pass == 0 ? k : (k * 5) % CH;
        chan_addr = 3'(ch); start_cs = 1'b1; even_sel = pass[0];
        tick(1'b1, -1, "R1 addr sample");
        chan_addr = 3'((ch + 3) % CH);
        tick(1'b0, ch, "R1 addressed write");
      end
    end

    // R2: select low
    for (int ch = 0; ch < CH; ch++) begin
      chan_addr = 3'(ch); start_cs = 1'b0;
      tick(1'b1, -1, "R2 sample");
      start_cs = 1'b1;
      tick(1'b0, -1, "R2 select low no write");
    end

    // R3: reserved code
    chan_addr = 3'd6; start_cs = 1'b1;
    tick(1'b1, -1, "R3 sample");
    tick(1'b0, -1, "R3 reserved no write");

    // R4 R5 R6 R7: all direction/slot combinations
    run_seq(1'b0, 1'b1);
    run_seq(1'b1, 1'b1);
    run_seq(1'b0, 1'b0);
    run_seq(1'b1, 1'b0);

    // R8: standby mid-sequence
    chan_addr = 3'd7; dir_down = 1'b0; even_sel = 1'b0; start_cs = 1'b1;
    tick(1'b1, -1, "R8 arm");
    start_cs = 1'b0;
    tick(1'b0, 0, "R8 first write");
    tick(1'b1, -1, "R8 off slot");
    standby = 1'b1;
    tick(1'b0, -1, "R8 standby clears");
    tick(1'b1, -1, "R8 standby held");
    standby = 1'b0;
    for (int k = 0; k < 4; k++) tick(k[0] ? 1'b1 : 1'b0, -1, "R8 no resume");
    chk("R9 word after standby", 64'(cap_word), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule